// File: doc/BRIEF.md
# Prioritized Interrupt Request and Enable Controller

This block keeps a five-bit request register and a five-bit enable register for five interrupt sources. It sets a request bit whenever the matching source line goes from low to high. Software can read and write both registers over a byte-wide port. A request bit stays set until it is serviced or cleared by software. A request is serviceable only while its enable bit is also set.

Among the serviceable requests, the lowest bit index wins. The block drives a pending flag, the winning index and the winning vector address. The vector addresses are spaced eight bytes apart, starting at 0x40. The dispatch logic returns an acknowledge carrying the serviced index. That acknowledge clears only that one request bit.

The global interrupt master switch, dispatch sequencing and stack handling are outside this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the request and enable bits are all 0, pending_o is low, and both registers read as 0xE0.
- R2: The request register is at address 0xFF0F and the enable register is at 0xFFFF. A read is combinational. Bits 7..5 always read as 1 and ignore writes. Any other address reads 0x00, and writes to it change nothing.
- R3: A low-to-high change on irq_src_i[n] sets request bit n, which is visible from the clock after that edge. A line held high does not set the bit again after it has been cleared.
- R4: A request whose enable bit is 0 raises no pending, but it stays latched. Setting the enable bit later makes it pending.
- R5: A write to the request register loads any pattern (for example 0x1F). This raises requests by hand or discards them, and raised requests are handled exactly like hardware ones.
- R6: pending_o is high exactly when some bit is set in both registers. irq_idx_o is then the lowest such bit index (bit 0 highest priority).
- R7: The bit order of the sources is vertical blank (0), display status (1), timer (2), serial (3), keypad (4). While pending_o is high, vector_o = 0x40 + 8*irq_idx_o (0x40, 0x48, 0x50, 0x58, 0x60).
- R8: When ack_i is high, only request bit ack_idx_i is cleared, and all other request bits remain.
- R9: If a request-register write and a rising edge fall in the same cycle, the edge's bit is set on top of the written value.
- R10: A request-register write in the same cycle as ack_i takes the written value, so the acknowledge has no effect. A rising edge on the acknowledged bit in the same cycle leaves that bit set.
- R11: ack_i with ack_idx_i of 5 or more changes no request bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 5 | Raw source lines, rising edge requests |
| reg_addr_i | input | 16 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| ack_i | input | 1 | Service acknowledge |
| ack_idx_i | input | 3 | Index of the serviced source |
| pending_o | output | 1 | A serviceable request exists |
| irq_idx_o | output | 3 | Winning source index |
| vector_o | output | 8 | Winning vector address |

## Verification
The assertions on edge capture take for granted that the source lines are low while reset is held. Under that condition, the checker's own copy of the previous line values matches the block's copy from the first clock on. The stimulus therefore keeps irq_src_i at zero throughout reset. It changes inputs only half a cycle away from the sampling edge, so every edge the checker sees is also seen by the block. Random acknowledges may name any index from 0 to 7, including a bit that is already clear, so the ignored-index case arises naturally.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC    = 5;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = 3;
    localparam int VEC_W      = 8;
    localparam int VEC_BASE   = 'h40;
    localparam int VEC_STRIDE = 8;
    localparam int FLAG_ADDR  = 'hFF0F;
    localparam int EN_ADDR    = 'hFFFF;

    typedef enum logic [IDX_W-1:0] {
        SRC_VBLANK = 3'd0,
        SRC_DSTAT  = 3'd1,
        SRC_TIMER  = 3'd2,
        SRC_SERIAL = 3'd3,
        SRC_KEYPAD = 3'd4
    } irq_src_e;
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
    parameter int N = 5
) (
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] prev_i,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign rise_o[g] = line_i[g] & ~prev_i[g];
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int N          = 5,
    parameter int IDX_W      = 3,
    parameter int VEC_W      = 8,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 8
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [VEC_W-1:0] vec_o
);
    always_comb begin
        idx_o = '0;
        // walk downward so the lowest set index is the last one kept
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |req_i;
        vec_o = VEC_W'(VEC_BASE + VEC_STRIDE * int'(idx_o));
    end
endmodule

// File: rtl/irq_reg_rd.sv
module irq_reg_rd #(
    parameter int N         = 5,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int FLAG_ADDR = 'hFF0F,
    parameter int EN_ADDR   = 'hFFFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      flag_i,
    input  logic [N-1:0]      en_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - N;

    always_comb begin
        if (addr_i == ADDR_W'(FLAG_ADDR))
            rdata_o = {{PAD_W{1'b1}}, flag_i};
        else if (addr_i == ADDR_W'(EN_ADDR))
            rdata_o = {{PAD_W{1'b1}}, en_i};
        else
            rdata_o = '0;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int N          = irq_pkg::NUM_SRC,
    parameter int ADDR_W     = irq_pkg::ADDR_W,
    parameter int DATA_W     = irq_pkg::DATA_W,
    parameter int IDX_W      = irq_pkg::IDX_W,
    parameter int VEC_W      = irq_pkg::VEC_W,
    parameter int VEC_BASE   = irq_pkg::VEC_BASE,
    parameter int VEC_STRIDE = irq_pkg::VEC_STRIDE,
    parameter int FLAG_ADDR  = irq_pkg::FLAG_ADDR,
    parameter int EN_ADDR    = irq_pkg::EN_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_src_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              ack_i,
    input  logic [IDX_W-1:0]  ack_idx_i,
    output logic              pending_o,
    output logic [IDX_W-1:0]  irq_idx_o,
    output logic [VEC_W-1:0]  vector_o
);
    typedef struct packed {
        logic [N-1:0] flag;
        logic [N-1:0] en;
        logic [N-1:0] src_prev;
    } state_t;

    state_t       state_d, state_q;
    logic [N-1:0] rise;
    logic [N-1:0] ack_mask;
    logic         wr_flag, wr_en;
    logic         wdata_unused;

    assign wdata_unused = ^reg_wdata_i[DATA_W-1:N];

    irq_rise_det #(.N(N)) u_rise (
        .line_i (irq_src_i),
        .prev_i (state_q.src_prev),
        .rise_o (rise)
    );

    irq_prio_sel #(
        .N(N), .IDX_W(IDX_W), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_sel (
        .req_i (state_q.flag & state_q.en),
        .any_o (pending_o),
        .idx_o (irq_idx_o),
        .vec_o (vector_o)
    );

    irq_reg_rd #(
        .N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
    ) u_rd (
        .addr_i  (reg_addr_i),
        .flag_i  (state_q.flag),
        .en_i    (state_q.en),
        .rdata_o (reg_rdata_o)
    );

    always_comb begin
        wr_flag  = reg_wr_i && (reg_addr_i == ADDR_W'(FLAG_ADDR));
        wr_en    = reg_wr_i && (reg_addr_i == ADDR_W'(EN_ADDR));
        ack_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (ack_i && (int'(ack_idx_i) == i)) ack_mask[i] = 1'b1;
        end

        state_d          = state_q;
        state_d.src_prev = irq_src_i;
        // a register write overrides the acknowledge; edges set on top of both
        if (wr_flag)
            state_d.flag = reg_wdata_i[N-1:0];
        else
            state_d.flag = state_q.flag & ~ack_mask;
        state_d.flag = state_d.flag | rise;
        if (wr_en)
            state_d.en = reg_wdata_i[N-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
    parameter int N          = 5,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 3,
    parameter int VEC_W      = 8,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 8,
    parameter int FLAG_ADDR  = 'hFF0F,
    parameter int EN_ADDR    = 'hFFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      irq_src_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              ack_i,
    input logic [IDX_W-1:0]  ack_idx_i,
    input logic              pending_o,
    input logic [IDX_W-1:0]  irq_idx_o,
    input logic [VEC_W-1:0]  vector_o,
    input logic [N-1:0]      flag_q,
    input logic [N-1:0]      en_q
);
    logic [N-1:0] prev_c, rise_c, mask_c, lower_c;
    logic         flag_wr_c;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_c <= '0;
        else        prev_c <= irq_src_i;
    end

    always_comb begin
        rise_c    = irq_src_i & ~prev_c;
        flag_wr_c = reg_wr_i && (reg_addr_i == ADDR_W'(FLAG_ADDR));
        mask_c    = '0;
        lower_c   = '0;
        for (int i = 0; i < N; i++) begin
            if (ack_i && int'(ack_idx_i) == i) mask_c[i] = 1'b1;
            if (i < int'(irq_idx_o)) lower_c[i] = 1'b1;
        end
    end

    // R3 / R9: an edge always lands in the request register
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c != '0) |=> ((flag_q & $past(rise_c)) == $past(rise_c)));

    // R6: the reported winner is serviceable and nothing ranks above it
    a_r6_winner_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> (flag_q[irq_idx_o] && en_q[irq_idx_o]
                       && ((flag_q & en_q & lower_c) == '0)));

    a_r6_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o |-> ((flag_q & en_q) == '0));

    // R7: vector spacing
    a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> (int'(vector_o) == VEC_BASE + VEC_STRIDE * int'(irq_idx_o)));

    // R8: the acknowledged bit drops unless an edge re-raises it
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !flag_wr_c && ((mask_c & rise_c) == '0)) |=> ((flag_q & $past(mask_c)) == '0));

    // R8 / R11: no other request bit is lost by an acknowledge
    a_r8_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !flag_wr_c) |=> ((($past(flag_q) & ~$past(mask_c)) & ~flag_q) == '0));

    // R2: unimplemented bits read as ones
    a_r2_pad_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr_i == ADDR_W'(FLAG_ADDR)) || (reg_addr_i == ADDR_W'(EN_ADDR)))
        |-> (&reg_rdata_o[DATA_W-1:N]));
endmodule

bind irq_prio_ctrl irq_prio_chk #(
    .N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
    .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_src_i   (irq_src_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rdata_o (reg_rdata_o),
    .ack_i       (ack_i),
    .ack_idx_i   (ack_idx_i),
    .pending_o   (pending_o),
    .irq_idx_o   (irq_idx_o),
    .vector_o    (vector_o),
    .flag_q      (state_q.flag),
    .en_q        (state_q.en)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    localparam logic [15:0] A_FLAG  = 16'hFF0F;
    localparam logic [15:0] A_EN    = 16'hFFFF;
    localparam logic [15:0] A_OTHER = 16'h1234;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  src;
    logic [15:0] addr;
    logic        wr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        ack;
    logic [2:0]  ack_idx;
    logic        pending;
    logic [2:0]  idx;
    logic [7:0]  vector;

    int n_chk  = 0;
    int n_fail = 0;
    logic [4:0] m_flag, m_en, m_prev;

    always #4 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ack_i(ack), .ack_idx_i(ack_idx), .pending_o(pending),
        .irq_idx_o(idx), .vector_o(vector)
    );

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        if (a == A_FLAG) return {3'b111, m_flag};
        if (a == A_EN)   return {3'b111, m_en};
        return 8'h00;
    endfunction

    function automatic int exp_idx();
        logic [4:0] r = m_flag & m_en;
        for (int i = 0; i < 5; i++) if (r[i]) return i;
        return 0;
    endfunction

    task automatic compare(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // drive one cycle, compare outputs against the model, then advance the model
    task automatic cyc(input logic [4:0] s, input logic w, input logic [15:0] a,
                       input logic [7:0] d, input logic k, input logic [2:0] ki,
                       input string tag);
        logic [4:0] rise, nf, mask;
        src = s; wr = w; addr = a; wdata = d; ack = k; ack_idx = ki;
        #1;
        compare(tag, "rdata", int'(rdata), int'(exp_rd(a)));
        compare(tag, "pending", int'(pending), int'((m_flag & m_en) != 0));
        if ((m_flag & m_en) != 0) begin
            compare(tag, "idx", int'(idx), exp_idx());
            compare(tag, "vector", int'(vector), 'h40 + 8 * exp_idx());
        end
        rise = s & ~m_prev;
        mask = (k && ki < 3'd5) ? (5'b1 << ki) : 5'b0;
        nf   = (w && a == A_FLAG) ? d[4:0] : (m_flag & ~mask);
        @(posedge clk);
        m_flag = nf | rise;
        if (w && a == A_EN) m_en = d[4:0];
        m_prev = s;
        @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, input logic [4:0] s, input string tag);
        cyc(s, 1'b0, a, 8'h00, 1'b0, 3'd0, tag);
    endtask

    task automatic wreg(input logic [15:0] a, input logic [7:0] d, input logic [4:0] s, input string tag);
        cyc(s, 1'b1, a, d, 1'b0, 3'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int sd;
        rst_n = 1'b0; src = '0; addr = A_FLAG; wr = 0; wdata = 0; ack = 0; ack_idx = 0;
        m_flag = '0; m_en = '0; m_prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_FLAG, 5'h00, "R1");
        rd(A_EN, 5'h00, "R1");

        // R2 register map, pad bits, foreign address
        wreg(A_EN, 8'h1F, 5'h00, "R2");
        rd(A_EN, 5'h00, "R2");
        wreg(A_OTHER, 8'hFF, 5'h00, "R2");
        rd(A_OTHER, 5'h00, "R2");
        rd(A_FLAG, 5'h00, "R2");
        wreg(A_EN, 8'h00, 5'h00, "R2");

        // R3 edge capture, held level does not re-raise
        rd(A_FLAG, 5'h04, "R3");
        rd(A_FLAG, 5'h04, "R3");
        wreg(A_FLAG, 8'h00, 5'h04, "R3");
        rd(A_FLAG, 5'h04, "R3");
        rd(A_FLAG, 5'h00, "R3");

        // R4 latched until enabled
        rd(A_FLAG, 5'h10, "R4");
        rd(A_FLAG, 5'h00, "R4");
        wreg(A_EN, 8'h10, 5'h00, "R4");
        rd(A_FLAG, 5'h00, "R4");

        // R5 software raise and discard
        wreg(A_FLAG, 8'h1F, 5'h00, "R5");
        wreg(A_EN, 8'h1F, 5'h00, "R5");
        rd(A_FLAG, 5'h00, "R5");
        wreg(A_FLAG, 8'h00, 5'h00, "R5");
        rd(A_FLAG, 5'h00, "R5");

        // R6 R7 R8 priority walk with acknowledges
        wreg(A_FLAG, 8'h1F, 5'h00, "R6");
        for (int k = 0; k < 5; k++)
            cyc(5'h00, 1'b0, A_FLAG, 8'h00, 1'b1, 3'(k), "R8");
        rd(A_FLAG, 5'h00, "R7");
        wreg(A_FLAG, 8'h16, 5'h00, "R6");
        cyc(5'h00, 1'b0, A_FLAG, 8'h00, 1'b1, 3'd2, "R8");
        rd(A_FLAG, 5'h00, "R8");

        // R9 write plus edge in the same cycle
        wreg(A_FLAG, 8'h01, 5'h08, "R9");
        rd(A_FLAG, 5'h00, "R9");

        // R10 write beats ack; edge beats ack on the same bit
        wreg(A_FLAG, 8'h0A, 5'h00, "R10");
        cyc(5'h00, 1'b1, A_FLAG, 8'h02, 1'b1, 3'd1, "R10");
        rd(A_FLAG, 5'h00, "R10");
        cyc(5'h08, 1'b0, A_FLAG, 8'h00, 1'b1, 3'd3, "R10");
        rd(A_FLAG, 5'h00, "R10");

        // R11 out-of-range acknowledge
        wreg(A_FLAG, 8'h1F, 5'h00, "R11");
        cyc(5'h00, 1'b0, A_FLAG, 8'h00, 1'b1, 3'd5, "R11");
        cyc(5'h00, 1'b0, A_FLAG, 8'h00, 1'b1, 3'd7, "R11");
        rd(A_FLAG, 5'h00, "R11");

        // random mix against the model
        sd = int'($urandom(32'h5EED_0042));
        for (int t = 0; t < 3000; t++) begin
            logic [15:0] a;
            int r = int'($urandom_range(0, 2));
            a = (r == 0) ? A_FLAG : (r == 1) ? A_EN : A_OTHER;
            cyc(5'($urandom), ($urandom_range(0, 7) == 0), a, 8'($urandom),
                ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'(exp_idx()),
                "R6 R7 R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule